// File: doc/BRIEF.md
# Placeholder L2 Cache Controller Register Block

This block presents the programming interface of an L2 cache controller to software, but has no cache behind it. It sits on a simple 32-bit memory-mapped slave port. When `sel` is high at a rising clock edge, one access takes place: a write if `wr_en` is high, otherwise a read. The block stores control, auxiliary control, tag latency, data latency and address-filter words. It returns a fixed identification word. It also returns a cache type word that picks up bits from the auxiliary control register each time it is read.

Every cache maintenance offset reads back as already complete. A small set of reserved offsets is accepted silently. Any other offset reads zero, leaves the state unchanged and raises a one-cycle error pulse. This lets boot software that programs and polls such a controller run unchanged on a system that has no L2 cache.

Top module: `l2c_stub`

## Requirements
- R1: Only address bits 11:0 select a register. Higher address bits have no effect, so the 4 KB window repeats.
- R2: A read at offset 0x000 returns ID_VALUE, which defaults to 0x410000C8. A write to offset 0x000 changes nothing and raises the error pulse.
- R3: A read at offset 0x004 forms a 4-bit code c = {aux[19:17], aux[16]}. It ORs (c<<18)|(c<<6) into the stored type word and returns the updated word. The ORed bits stay set on later reads, even after the auxiliary register changes. A write to offset 0x004 changes nothing and raises the error pulse.
- R4: The stored type word resets to the parameter TYPE_RESET, which defaults to 0x1C100100. Reset clears every bit that earlier reads ORed in. With the auxiliary reset value, the first read after reset returns 0x1C180180.
- R5: The control register at 0x100 keeps only bit 0 of a write. Bits 31:1 always read as zero. Its reset value is 0.
- R6: The auxiliary control register at 0x104 resets to 0x02020000 and stores full 32-bit writes.
- R7: The registers at 0x108 (tag latency), 0x10C (data latency), 0xC00 (filter start) and 0xC04 (filter end) reset to 0 and store full 32-bit writes.
- R8: Offsets from 0x730 to 0x7FF inclusive read as 0, meaning the operation is complete. Writes to them are discarded. Accesses to them never raise the error pulse.
- R9: Offsets 0xF40, 0xF60 and 0xF80 read as 0, discard writes and never raise the error pulse.
- R10: Any other offset reads 0, discards writes and raises `err` for exactly one cycle. This includes 0x72C, 0x800 and 0xF44.
- R11: Read data appears on `rdata` in the cycle after the read is sampled. It holds its value until the next read. `err` is registered and has the same one-cycle latency. After reset, `rdata` and `err` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Access request, sampled at the rising edge |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address; only bits 11:0 are decoded |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after the read |
| err | output | 1 | One-cycle pulse for an access to an undefined offset |

## Verification
Both results of an access, the read word and the error flag, are due one cycle after the edge that samples the request. The type-word side effect is visible in that same returned word. The driver pushes one expected item for every cycle it drives, whether an access or an idle cycle. The monitor takes a count of due items at each rising edge and compares them at the next falling edge, so each item is checked exactly one cycle after it was issued. The idle items after a bad access confirm that the error pulse lasts only one cycle. The reads after reserved-offset writes confirm that no stored register changed.

// File: rtl/l2c_stub_pkg.sv
package l2c_stub_pkg;

  localparam int WORD_W = 32;
  localparam int WIN_BITS = 12;
  localparam int CODE_W = 4;

  typedef enum logic [3:0] {
    RG_ID, RG_TYPE, RG_CTRL, RG_AUX, RG_TAGLAT, RG_DATLAT,
    RG_FLT_LO, RG_FLT_HI, RG_MAINT, RG_QUIET, RG_BAD
  } region_e;

  localparam logic [WIN_BITS-1:0] OFF_ID      = 12'h000;
  localparam logic [WIN_BITS-1:0] OFF_TYPE    = 12'h004;
  localparam logic [WIN_BITS-1:0] OFF_CTRL    = 12'h100;
  localparam logic [WIN_BITS-1:0] OFF_AUX     = 12'h104;
  localparam logic [WIN_BITS-1:0] OFF_TAGLAT  = 12'h108;
  localparam logic [WIN_BITS-1:0] OFF_DATLAT  = 12'h10C;
  localparam logic [WIN_BITS-1:0] OFF_FLT_LO  = 12'hC00;
  localparam logic [WIN_BITS-1:0] OFF_FLT_HI  = 12'hC04;
  localparam logic [WIN_BITS-1:0] MAINT_FIRST = 12'h730;
  localparam logic [WIN_BITS-1:0] MAINT_END   = 12'h800;
  localparam logic [WIN_BITS-1:0] OFF_QUIET0  = 12'hF40;
  localparam logic [WIN_BITS-1:0] OFF_QUIET1  = 12'hF60;
  localparam logic [WIN_BITS-1:0] OFF_QUIET2  = 12'hF80;

  localparam logic [WORD_W-1:0] AUX_RESET = 32'h0202_0000;

  // Type code from the auxiliary word: aux[19:17] -> code[3:1], aux[16] -> code[0]
  function automatic logic [CODE_W-1:0] type_code(input logic [WORD_W-1:0] aux);
    return {aux[19:17], aux[16]};
  endfunction

  // Code copied into the type word at bit 18 and at bit 6
  function automatic logic [WORD_W-1:0] type_merge(input logic [WORD_W-1:0] cur,
                                                   input logic [CODE_W-1:0] code);
    logic [WORD_W-1:0] wide;
    wide = {{(WORD_W-CODE_W){1'b0}}, code};
    return cur | (wide << 18) | (wide << 6);
  endfunction

  // Region served by plain register slot k
  function automatic region_e plain_region(input int k);
    case (k)
      0:       return RG_TAGLAT;
      1:       return RG_DATLAT;
      2:       return RG_FLT_LO;
      default: return RG_FLT_HI;
    endcase
  endfunction

endpackage

// File: rtl/l2c_stub_decode.sv
module l2c_stub_decode
  import l2c_stub_pkg::*;
(
  input  logic [WIN_BITS-1:0] off,
  output region_e             region
);

  logic in_maint;
  assign in_maint = (off >= MAINT_FIRST) && (off < MAINT_END);

  always_comb begin
    if (in_maint) begin
      region = RG_MAINT;
    end else begin
      case (off)
        OFF_ID:     region = RG_ID;
        OFF_TYPE:   region = RG_TYPE;
        OFF_CTRL:   region = RG_CTRL;
        OFF_AUX:    region = RG_AUX;
        OFF_TAGLAT: region = RG_TAGLAT;
        OFF_DATLAT: region = RG_DATLAT;
        OFF_FLT_LO: region = RG_FLT_LO;
        OFF_FLT_HI: region = RG_FLT_HI;
        OFF_QUIET0, OFF_QUIET1, OFF_QUIET2: region = RG_QUIET;
        default:    region = RG_BAD;
      endcase
    end
  end

endmodule

// File: rtl/l2c_stub_regfile.sv
module l2c_stub_regfile
  import l2c_stub_pkg::*;
#(
  parameter logic [WORD_W-1:0] ID_VALUE   = 32'h4100_00C8,
  parameter logic [WORD_W-1:0] TYPE_RESET = 32'h1C10_0100,
  parameter int                NPLAIN     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit,
  input  logic              wr_hit,
  input  region_e           region,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_value
);

  logic                         ctrl_bit;
  logic [WORD_W-1:0]            aux_q;
  logic [WORD_W-1:0]            type_q;
  logic [NPLAIN-1:0][WORD_W-1:0] plain_q;

  // Named events for the assertions
  logic              type_read;
  logic [WORD_W-1:0] type_next;
  assign type_read = rd_hit && (region == RG_TYPE);
  assign type_next = type_merge(type_q, type_code(aux_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_bit <= 1'b0;
      aux_q    <= AUX_RESET;
      type_q   <= TYPE_RESET;
    end else begin
      if (wr_hit && region == RG_CTRL) ctrl_bit <= wdata[0];
      if (wr_hit && region == RG_AUX)  aux_q    <= wdata;
      if (type_read)                   type_q   <= type_next;
    end
  end

  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (wr_hit && region == plain_region(g)) q <= wdata;
    end
    assign plain_q[g] = q;
  end

  always_comb begin
    case (region)
      RG_ID:     rd_value = ID_VALUE;
      RG_TYPE:   rd_value = type_next;
      RG_CTRL:   rd_value = {{(WORD_W-1){1'b0}}, ctrl_bit};
      RG_AUX:    rd_value = aux_q;
      RG_TAGLAT: rd_value = plain_q[0];
      RG_DATLAT: rd_value = plain_q[1];
      RG_FLT_LO: rd_value = plain_q[2];
      RG_FLT_HI: rd_value = plain_q[NPLAIN-1];
      default:   rd_value = '0;
    endcase
  end

  AST_TYPE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((type_q & $past(type_q)) == $past(type_q))); // R3

  AST_RESERVED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (region == RG_MAINT || region == RG_QUIET || region == RG_BAD))
    |=> ($stable(aux_q) && $stable(plain_q) && $stable(ctrl_bit) && $stable(type_q))); // R8

endmodule

// File: rtl/l2c_stub.sv
module l2c_stub
  import l2c_stub_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [WORD_W-1:0] ID_VALUE   = 32'h4100_00C8,
  parameter logic [WORD_W-1:0] TYPE_RESET = 32'h1C10_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              err
);

  region_e           region;
  logic              rd_hit;
  logic              wr_hit;
  logic              bad_access;
  logic [WORD_W-1:0] rd_value;

  l2c_stub_decode u_decode (
    .off    (addr[WIN_BITS-1:0]),
    .region (region)
  );

  assign rd_hit = sel && !wr_en;
  assign wr_hit = sel && wr_en;
  assign bad_access = (sel && region == RG_BAD) ||
                      (wr_hit && (region == RG_ID || region == RG_TYPE));

  l2c_stub_regfile #(
    .ID_VALUE   (ID_VALUE),
    .TYPE_RESET (TYPE_RESET)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_hit   (rd_hit),
    .wr_hit   (wr_hit),
    .region   (region),
    .wdata    (wdata),
    .rd_value (rd_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (rd_hit) rdata <= rd_value;
      err <= bad_access;
    end
  end

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && region == RG_ID) |=> (rdata == ID_VALUE)); // R2

  AST_CTRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && region == RG_CTRL) |=> (rdata[WORD_W-1:1] == '0)); // R5

  AST_MAINT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && region == RG_MAINT) |=> (rdata == '0 && !err)); // R8

  AST_QUIET_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && region == RG_QUIET) |=> (!err && (wr_en || rdata == '0))); // R9

  AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && region == RG_BAD) |=> err); // R10

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_access |=> !err); // R11

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(rdata)); // R11

endmodule

// File: tb/l2c_stub_bench.sv
module l2c_stub_bench;

  localparam logic [31:0] ID_EXP   = 32'h4100_00C8;
  localparam logic [31:0] TYPE_DEF = 32'h1C10_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;

  always #2 clk = ~clk;

  l2c_stub u_l2c_stub (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
  );

  typedef struct {
    bit          chk_rd;
    logic [31:0] rd;
    logic        er;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 0;

  // Bench-side model state
  logic [31:0] m_type, m_aux, m_ctrl, m_tag, m_dat, m_flo, m_fhi;

  task automatic model_reset();
    m_type = TYPE_DEF; m_aux = 32'h0202_0000; m_ctrl = 0;
    m_tag = 0; m_dat = 0; m_flo = 0; m_fhi = 0;
  endtask

  function automatic logic [31:0] code_of(logic [31:0] a);
    return ((a >> 16) & 32'h1) | (((a >> 17) & 32'h7) << 1);
  endfunction

  task automatic model_acc(bit w, logic [31:0] a, logic [31:0] d,
                           output logic [31:0] rv, output logic er);
    logic [11:0] o;
    o = a[11:0];
    rv = 0; er = 0;
    if (o >= 12'h730 && o <= 12'h7FF) begin
    end else if (o == 12'hF40 || o == 12'hF60 || o == 12'hF80) begin
    end else begin
      case (o)
        12'h000: if (w) er = 1; else rv = ID_EXP;
        12'h004: if (w) er = 1;
                 else begin
                   m_type = m_type | (code_of(m_aux) * 32'h0004_0040);
                   rv = m_type;
                 end
        12'h100: if (w) m_ctrl = d & 32'h1; else rv = m_ctrl;
        12'h104: if (w) m_aux = d; else rv = m_aux;
        12'h108: if (w) m_tag = d; else rv = m_tag;
        12'h10C: if (w) m_dat = d; else rv = m_dat;
        12'hC00: if (w) m_flo = d; else rv = m_flo;
        12'hC04: if (w) m_fhi = d; else rv = m_fhi;
        default: er = 1;
      endcase
    end
  endtask

  task automatic acc(bit w, logic [31:0] a, logic [31:0] d, string tag);
    item_t it;
    logic [31:0] rv;
    logic er;
    @(negedge clk);
    sel = 1; wr_en = w; addr = a; wdata = d;
    model_acc(w, a, d, rv, er);
    it.chk_rd = !w; it.rd = rv; it.er = er; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd(logic [31:0] a, string tag);
    acc(0, a, 32'h0, tag);
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d, string tag);
    acc(1, a, d, tag);
  endtask

  task automatic idle(string tag);
    item_t it;
    @(negedge clk);
    sel = 0; wr_en = 0;
    it.chk_rd = 0; it.rd = 0; it.er = 0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    idle("drain"); idle("drain");
    @(negedge clk);
    rst_n = 0; sel = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
    check("R11 reset rdata", rdata, 32'h0);
    check("R11 reset err", {31'b0, err}, 32'h0);
  endtask

  // Monitor: items due at a rising edge are compared at the next falling edge
  initial begin
    int n_due;
    forever begin
      @(posedge clk);
      n_due = q.size();
      @(negedge clk);
      if (n_due > 0 && rst_n) begin
        item_t it;
        it = q.pop_front();
        if (it.chk_rd) check({it.tag, " rdata"}, rdata, it.rd);
        check({it.tag, " err"}, {31'b0, err}, {31'b0, it.er});
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R11 reset rdata", rdata, 32'h0);
    check("R11 reset err", {31'b0, err}, 32'h0);

    rd(32'h000, "R2 id read");
    wr(32'h000, 32'hFFFF_FFFF, "R2 id write error");
    rd(32'h000, "R2 id after write");
    rd(32'h104, "R6 aux reset");
    rd(32'h100, "R5 ctrl reset");
    rd(32'h108, "R7 tag reset");
    rd(32'h10C, "R7 data reset");
    rd(32'hC00, "R7 flt lo reset");
    rd(32'hC04, "R7 flt hi reset");

    rd(32'h004, "R4 type first read");
    wr(32'h104, 32'h000F_0000, "R6 aux write");
    rd(32'h104, "R6 aux readback");
    rd(32'h004, "R3 type merge all ones");
    wr(32'h104, 32'h0000_0000, "R6 aux clear");
    rd(32'h004, "R3 type sticky");
    wr(32'h004, 32'h0, "R3 type write error");
    rd(32'h004, "R3 type after write");
    wr(32'h104, 32'h0001_0000, "R6 aux bit16");
    rd(32'h004, "R3 type bit16 code");

    wr(32'h100, 32'hFFFF_FFFF, "R5 ctrl write ones");
    rd(32'h100, "R5 ctrl keeps bit0");
    wr(32'h100, 32'hFFFF_FFFE, "R5 ctrl write bit0 clear");
    rd(32'h100, "R5 ctrl cleared");

    wr(32'h108, 32'hA5A5_5A5A, "R7 tag write");
    wr(32'h10C, 32'h1234_5678, "R7 data write");
    wr(32'hC00, 32'hFFFF_0001, "R7 flt lo write");
    wr(32'hC04, 32'h8000_0000, "R7 flt hi write");
    rd(32'h108, "R7 tag readback");
    rd(32'h10C, "R7 data readback");
    rd(32'hC00, "R7 flt lo readback");
    rd(32'hC04, "R7 flt hi readback");

    rd(32'h730, "R8 maint first");
    rd(32'h7FC, "R8 maint last");
    wr(32'h740, 32'hDEAD_BEEF, "R8 maint write");
    rd(32'h740, "R8 maint after write");
    rd(32'h72C, "R10 below maint");
    rd(32'h800, "R10 maint end");

    rd(32'hF40, "R9 quiet F40");
    wr(32'hF60, 32'hFFFF_FFFF, "R9 quiet F60 write");
    rd(32'hF80, "R9 quiet F80");
    rd(32'hF44, "R10 near quiet");

    wr(32'h110, 32'hFFFF_FFFF, "R10 bad write");
    idle("R10 err one cycle");
    idle("R10 err stays low");
    rd(32'h010, "R10 bad read");
    rd(32'h104, "R10 aux unchanged");
    rd(32'h108, "R10 tag unchanged");
    rd(32'h100, "R10 ctrl unchanged");

    rd(32'h1234_5104, "R1 alias aux");
    wr(32'hABCD_F10C, 32'h0BAD_F00D, "R1 alias data write");
    rd(32'h0000_010C, "R1 alias data read");
    wr(32'h0000_1108, 32'h0000_0042, "R1 alias tag write");
    rd(32'h0000_0108, "R1 alias tag read");

    do_reset();
    rd(32'h004, "R4 type after reset");
    rd(32'h104, "R6 aux after reset");
    rd(32'hC00, "R7 flt lo after reset");

    idle("end"); idle("end"); idle("end");
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule